// File: doc/BRIEF.md
# Receive Mailbox Bank with Alternating Last Mailbox

This block holds the message storage for a CAN-style controller. It has fifteen mailboxes, each holding a 15-byte frame. Mailboxes 1 to 14 have one buffer each, and a control input sets each of them for transmit or receive. Mailbox 15 only receives. It owns two buffers and uses them in turn, so a new frame can land while software is still working through the previous one.

The protocol engine hands over a complete received frame in one cycle, together with the target mailbox number. The CPU sees all mailboxes through a 256-byte window, one mailbox per 16-byte slot:

- Slot 0 of the window belongs to global registers kept outside this block.
- The last byte of every slot is reserved.
- The CPU reads bytes from the window and writes bytes into the single-buffer mailboxes, for example to prepare a transmit frame.
- The CPU returns a buffer to the block by pulsing a release strobe with the mailbox number.

Each mailbox reports a new-data flag and a message-lost flag. For mailbox 15, the window always shows the older unread buffer.

Top module: `mbox_bank`

## Requirements
- R1: Address bits [7:4] select the mailbox (1 to 15) and bits [3:0] select the byte (0 to 14). Byte k of a mailbox holds bits [8k+7:8k] of the stored frame. The read data follows the address in the same cycle.
- R2: Reads of slot 0 (addresses 0x00 to 0x0F) and of byte 15 of any slot return 0. CPU writes to those addresses change no stored byte.
- R3: A store into mailbox n (1 to 14) whose `tx_mode[n-1]` is 0 replaces its frame and sets `new_data[n-1]` one cycle later. A store into a mailbox whose `tx_mode` bit is 1 is ignored.
- R4: A CPU write changes one byte of mailboxes 1 to 14 from the next cycle on. Writes into mailbox 15 are ignored. If a store hits the same mailbox in the same cycle, the store wins.
- R5: A release strobe for mailbox n clears `new_data[n-1]` and `msg_lost[n-1]` when no store hits that buffer in the same cycle.
- R6: A store into a mailbox 1 to 14 whose new-data flag is still set overwrites the frame and sets its `msg_lost` bit.
- R7: In mailbox 15, the first frame into an empty mailbox appears in the window. A second frame, arriving while the window frame is unread, goes to the other buffer, and the window keeps showing the first frame.
- R8: With both buffers of mailbox 15 unread, a further frame overwrites the buffer not shown in the window and sets `msg_lost[14]`. The window frame is untouched.
- R9: A release of mailbox 15 frees the window buffer. If the other buffer holds new data, the window switches to it and `new_data[14]` stays 1. Otherwise `new_data[14]` becomes 0.
- R10: When a store and a release hit the same mailbox 15 buffer in one cycle, the store wins: `new_data[14]` stays 1 and the window shows the new frame.
- R11: After reset every flag is 0 and every byte of the window reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Frame store strobe from the protocol engine |
| st_box | input | 4 | Target mailbox of the store (1 to 15) |
| st_frame | input | 120 | Frame to store, byte k at bits [8k+7:8k] |
| tx_mode | input | 14 | Per-mailbox transmit setting for mailboxes 1 to 14 (bit n-1 is mailbox n) |
| cpu_addr | input | 8 | CPU byte address in the window |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte for cpu_addr |
| rel_valid | input | 1 | CPU release strobe |
| rel_box | input | 4 | Mailbox being released (1 to 15) |
| new_data | output | 15 | New-data flag per mailbox (bit n-1 is mailbox n) |
| msg_lost | output | 15 | Message-lost flag per mailbox (bit n-1 is mailbox n) |

## Verification
The assertions check the following on every cycle:
- reserved addresses read zero;
- a store into a receive mailbox raises its flag;
- a store into a transmit mailbox leaves all flags alone;
- a plain release clears both flags;
- a store into a full mailbox 15 raises its lost flag;
- a store on the window buffer wins over a release;
- the window of mailbox 15 never points at an empty buffer while the other one holds data.

Three things only the bench scenarios can show, because they depend on the frame contents over time:
- which frame sits behind the window after a sequence of stores and releases;
- that an overwrite hits the newer buffer and spares the older one;
- that byte writes and ignored writes leave exactly the right bytes behind.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // Per-buffer occupancy of the alternating mailbox
    typedef struct packed {
        logic nd;    // unread frame present
    } buf_flag_t;

    // Which of the two alternating buffers a store lands in
    typedef enum logic [0:0] {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_sel_e;
endpackage

// File: rtl/mbox_addr_dec.sv
module mbox_addr_dec #(
    parameter int ADDR_W  = 8,
    parameter int SLOT_W  = 4,
    parameter int BYTES   = 15,
    parameter int NUM_BOX = 15,
    localparam int IDX_W  = ADDR_W - SLOT_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output logic [IDX_W-1:0]  idx,
    output logic              in_box
);
    always_comb begin
        slot   = addr[ADDR_W-1 -: SLOT_W];
        idx    = addr[IDX_W-1:0];
        in_box = (slot != '0) && (slot <= SLOT_W'(NUM_BOX)) && (int'(idx) < BYTES);
    end
endmodule

// File: rtl/mbox_single.sv
module mbox_single #(
    parameter int BYTES = 15,
    parameter int BW    = 8,
    parameter int IDX_W = 4,
    localparam int FRAME_W = BYTES * BW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_en,
    input  logic [FRAME_W-1:0] st_frame,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [BW-1:0]      wr_byte,
    input  logic               rel,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [BW-1:0]      rd_byte,
    output logic               nd,
    output logic               lost
);
    typedef struct packed {
        logic [BYTES-1:0][BW-1:0] bytes;
        logic                     nd;
        logic                     lost;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (st_en) begin
            // a full frame store beats byte writes and release
            s_d.bytes = st_frame;
            s_d.nd    = 1'b1;
            if (s_q.nd) begin
                s_d.lost = 1'b1;
            end else if (rel) begin
                s_d.lost = 1'b0;
            end
        end else begin
            if (wr_en && (int'(wr_idx) < BYTES)) begin
                s_d.bytes[wr_idx] = wr_byte;
            end
            if (rel) begin
                s_d.nd   = 1'b0;
                s_d.lost = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_byte = '0;
        if (int'(rd_idx) < BYTES) begin
            rd_byte = s_q.bytes[rd_idx];
        end
        nd   = s_q.nd;
        lost = s_q.lost;
    end
endmodule

// File: rtl/mbox_dual.sv
module mbox_dual
    import mbox_pkg::*;
#(
    parameter int BYTES = 15,
    parameter int BW    = 8,
    parameter int IDX_W = 4,
    localparam int FRAME_W = BYTES * BW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_en,
    input  logic [FRAME_W-1:0] st_frame,
    input  logic               rel,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [BW-1:0]      rd_byte,
    output logic               nd,
    output logic               lost,
    output logic [1:0]         buf_nd,
    output logic               win_sel
);
    typedef struct packed {
        logic [1:0][BYTES-1:0][BW-1:0] bufs;
        buf_flag_t [1:0]               flg;
        buf_sel_e                      sel;
        logic                          lost;
    } state_t;

    state_t   s_d, s_q;
    buf_sel_e tgt;
    logic     full;
    logic     rel_hits_store;

    always_comb begin
        s_d  = s_q;
        full = s_q.flg[0].nd && s_q.flg[1].nd;
        // the window buffer takes a frame when empty, otherwise the other one
        tgt  = s_q.flg[s_q.sel].nd ? buf_sel_e'(~s_q.sel) : s_q.sel;
        rel_hits_store = st_en && (tgt == s_q.sel);

        if (st_en) begin
            s_d.bufs[tgt]   = st_frame;
            s_d.flg[tgt].nd = 1'b1;
        end

        if (st_en && full) begin
            s_d.lost = 1'b1;
        end else if (rel) begin
            s_d.lost = 1'b0;
        end

        if (rel && !rel_hits_store) begin
            s_d.flg[s_q.sel].nd = 1'b0;
            if (s_d.flg[~s_q.sel].nd) begin
                s_d.sel = buf_sel_e'(~s_q.sel);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_byte = '0;
        if (int'(rd_idx) < BYTES) begin
            rd_byte = s_q.bufs[s_q.sel][rd_idx];
        end
        nd      = s_q.flg[0].nd || s_q.flg[1].nd;
        lost    = s_q.lost;
        buf_nd  = {s_q.flg[1].nd, s_q.flg[0].nd};
        win_sel = s_q.sel;
    end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
    parameter int NUM_GEN = 14,
    parameter int BYTES   = 15,
    parameter int BW      = 8,
    parameter int ADDR_W  = 8,
    parameter int SLOT_W  = 4,
    localparam int FRAME_W = BYTES * BW,
    localparam int NUM_BOX = NUM_GEN + 1,
    localparam int IDX_W   = ADDR_W - SLOT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    input  logic [SLOT_W-1:0]  st_box,
    input  logic [FRAME_W-1:0] st_frame,
    input  logic [NUM_GEN-1:0] tx_mode,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_wr,
    input  logic [BW-1:0]      cpu_wdata,
    output logic [BW-1:0]      cpu_rdata,
    input  logic               rel_valid,
    input  logic [SLOT_W-1:0]  rel_box,
    output logic [NUM_BOX-1:0] new_data,
    output logic [NUM_BOX-1:0] msg_lost
);
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  idx;
    logic              in_box;
    logic [BW-1:0]     gen_rd [NUM_GEN];
    logic [BW-1:0]     dual_rd;
    logic [1:0]        dual_nd;
    logic              dual_sel;

    mbox_addr_dec #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W),
        .BYTES  (BYTES),
        .NUM_BOX(NUM_BOX)
    ) u_dec (
        .addr  (cpu_addr),
        .slot  (slot),
        .idx   (idx),
        .in_box(in_box)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_box
        logic st_en, wr_en, rel;
        always_comb begin
            st_en = st_valid && (st_box == SLOT_W'(g + 1)) && !tx_mode[g];
            wr_en = cpu_wr && in_box && (slot == SLOT_W'(g + 1));
            rel   = rel_valid && (rel_box == SLOT_W'(g + 1));
        end
        mbox_single #(
            .BYTES(BYTES),
            .BW   (BW),
            .IDX_W(IDX_W)
        ) u_box (
            .clk     (clk),
            .rst_n   (rst_n),
            .st_en   (st_en),
            .st_frame(st_frame),
            .wr_en   (wr_en),
            .wr_idx  (idx),
            .wr_byte (cpu_wdata),
            .rel     (rel),
            .rd_idx  (idx),
            .rd_byte (gen_rd[g]),
            .nd      (new_data[g]),
            .lost    (msg_lost[g])
        );
    end

    logic dual_st, dual_rel;
    always_comb begin
        dual_st  = st_valid && (st_box == SLOT_W'(NUM_BOX));
        dual_rel = rel_valid && (rel_box == SLOT_W'(NUM_BOX));
    end

    mbox_dual #(
        .BYTES(BYTES),
        .BW   (BW),
        .IDX_W(IDX_W)
    ) u_dual (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_en   (dual_st),
        .st_frame(st_frame),
        .rel     (dual_rel),
        .rd_idx  (idx),
        .rd_byte (dual_rd),
        .nd      (new_data[NUM_BOX-1]),
        .lost    (msg_lost[NUM_BOX-1]),
        .buf_nd  (dual_nd),
        .win_sel (dual_sel)
    );

    always_comb begin
        cpu_rdata = '0;
        if (in_box) begin
            if (slot == SLOT_W'(NUM_BOX)) begin
                cpu_rdata = dual_rd;
            end else begin
                for (int i = 0; i < NUM_GEN; i++) begin
                    if (slot == SLOT_W'(i + 1)) begin
                        cpu_rdata = gen_rd[i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
    parameter int NUM_GEN = 14,
    parameter int BW      = 8,
    parameter int ADDR_W  = 8,
    parameter int SLOT_W  = 4,
    localparam int NUM_BOX = NUM_GEN + 1,
    localparam int IDX_W   = ADDR_W - SLOT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               st_valid,
    input logic [SLOT_W-1:0]  st_box,
    input logic [NUM_GEN-1:0] tx_mode,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic [BW-1:0]      cpu_rdata,
    input logic               rel_valid,
    input logic [SLOT_W-1:0]  rel_box,
    input logic [NUM_BOX-1:0] new_data,
    input logic [NUM_BOX-1:0] msg_lost,
    input logic [1:0]         dual_nd,
    input logic               dual_sel
);
    logic [SLOT_W-1:0] st_m1, rel_m1;
    logic              st_gen, rel_gen;
    always_comb begin
        st_m1   = st_box - SLOT_W'(1);
        rel_m1  = rel_box - SLOT_W'(1);
        st_gen  = (st_box != '0) && (st_box <= SLOT_W'(NUM_GEN));
        rel_gen = (rel_box != '0) && (rel_box <= SLOT_W'(NUM_GEN));
    end

    // R2
    rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_addr[IDX_W-1:0] == '1) || (cpu_addr[ADDR_W-1 -: SLOT_W] == '0)) |-> (cpu_rdata == '0));

    // R3
    rx_store_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_gen && !tx_mode[st_m1]) |=> new_data[$past(st_m1)]);

    // R3
    tx_store_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_gen && tx_mode[st_m1] && !rel_valid) |=> ($stable(new_data) && $stable(msg_lost)));

    // R5
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_gen && !(st_valid && (st_box == rel_box)))
        |=> (!new_data[$past(rel_m1)] && !msg_lost[$past(rel_m1)]));

    // R8
    dual_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && (st_box == SLOT_W'(NUM_BOX)) && (dual_nd == 2'b11)) |=> msg_lost[NUM_BOX-1]);

    // R7 R9
    window_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_nd != 2'b00) |-> dual_nd[dual_sel]);

    // R10
    store_beats_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && (st_box == SLOT_W'(NUM_BOX)) && rel_valid && (rel_box == SLOT_W'(NUM_BOX)))
        |=> new_data[NUM_BOX-1]);
endmodule

bind mbox_bank mbox_bank_chk #(
    .NUM_GEN(NUM_GEN),
    .BW     (BW),
    .ADDR_W (ADDR_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_box   (st_box),
    .tx_mode  (tx_mode),
    .cpu_addr (cpu_addr),
    .cpu_rdata(cpu_rdata),
    .rel_valid(rel_valid),
    .rel_box  (rel_box),
    .new_data (new_data),
    .msg_lost (msg_lost),
    .dual_nd  (dual_nd),
    .dual_sel (dual_sel)
);

// File: tb/sim_mbox_bank.sv
module sim_mbox_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic [3:0]   st_box = '0;
    logic [119:0] st_frame = '0;
    logic [13:0]  tx_mode = 14'b00_0000_0000_0101;
    logic [7:0]   cpu_addr = '0;
    logic         cpu_wr = 1'b0;
    logic [7:0]   cpu_wdata = '0;
    logic [7:0]   cpu_rdata;
    logic         rel_valid = 1'b0;
    logic [3:0]   rel_box = '0;
    logic [14:0]  new_data;
    logic [14:0]  msg_lost;

    always #10 clk = ~clk;

    mbox_bank u0 (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_box(st_box),
        .st_frame(st_frame), .tx_mode(tx_mode), .cpu_addr(cpu_addr),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .rel_valid(rel_valid), .rel_box(rel_box), .new_data(new_data),
        .msg_lost(msg_lost)
    );

    // expected state, built from the requirements
    logic [119:0] mf [1:14];
    logic [119:0] mb [2];
    logic [1:0]   mnd15;
    logic         msel;
    logic         mlost15;
    logic [14:0]  xnd;
    logic [14:0]  xlost;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [119:0] F_SEQ = 120'h0E0D0C0B0A09080706050403020100;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        int s, b;
        s = int'(a[7:4]);
        b = int'(a[3:0]);
        if (s == 0 || b == 15) return 8'h00;
        if (s == 15) return mb[msel][b*8 +: 8];
        return mf[s][b*8 +: 8];
    endfunction

    function automatic logic [119:0] rand_frame();
        logic [127:0] t;
        t = {$urandom(), $urandom(), $urandom(), $urandom()};
        return t[119:0];
    endfunction

    task automatic model_reset();
        for (int k = 1; k <= 14; k++) mf[k] = '0;
        mb[0] = '0; mb[1] = '0;
        mnd15 = 2'b00; msel = 1'b0; mlost15 = 1'b0;
        xnd = '0; xlost = '0;
    endtask

    task automatic model_step(input logic sv, input logic [3:0] sb, input logic [119:0] sf,
                              input logic w, input logic [7:0] wa, input logic [7:0] wd,
                              input logic rl, input logic [3:0] rb);
        logic s, r, tgt, full;
        for (int k = 1; k <= 14; k++) begin
            s = sv && (sb == 4'(k)) && !tx_mode[k-1];
            r = rl && (rb == 4'(k));
            if (s) begin
                if (xnd[k-1]) xlost[k-1] = 1'b1;
                else if (r) xlost[k-1] = 1'b0;
                mf[k] = sf;
                xnd[k-1] = 1'b1;
            end else begin
                if (w && (wa[7:4] == 4'(k)) && (wa[3:0] != 4'hF))
                    mf[k][int'(wa[3:0])*8 +: 8] = wd;
                if (r) begin
                    xnd[k-1] = 1'b0;
                    xlost[k-1] = 1'b0;
                end
            end
        end
        s = sv && (sb == 4'd15);
        r = rl && (rb == 4'd15);
        tgt = mnd15[msel] ? !msel : msel;
        full = mnd15[0] && mnd15[1];
        if (s) begin
            mb[tgt] = sf;
            mnd15[tgt] = 1'b1;
        end
        if (s && full) mlost15 = 1'b1;
        else if (r) mlost15 = 1'b0;
        if (r && !(s && (tgt == msel))) begin
            mnd15[msel] = 1'b0;
            if (mnd15[!msel]) msel = !msel;
        end
        xnd[14] = mnd15[0] | mnd15[1];
        xlost[14] = mlost15;
    endtask

    task automatic cyc(input logic sv, input logic [3:0] sb, input logic [119:0] sf,
                       input logic w, input logic [7:0] wa, input logic [7:0] wd,
                       input logic rl, input logic [3:0] rb);
        @(negedge clk);
        st_valid = sv; st_box = sb; st_frame = sf;
        cpu_wr = w; cpu_addr = wa; cpu_wdata = wd;
        rel_valid = rl; rel_box = rb;
        @(posedge clk);
        model_step(sv, sb, sf, w, wa, wd, rl, rb);
        #2;
        st_valid = 1'b0; cpu_wr = 1'b0; rel_valid = 1'b0;
        st_box = '0; rel_box = '0; cpu_addr = '0;
    endtask

    task automatic chk_flags(input string tag);
        chk(new_data === xnd, tag, "new_data", 32'(new_data), 32'(xnd));
        chk(msg_lost === xlost, tag, "msg_lost", 32'(msg_lost), 32'(xlost));
    endtask

    task automatic chk_rd(input logic [7:0] a, input string tag);
        logic [7:0] e;
        cpu_addr = a;
        #1;
        e = exp_rd(a);
        chk(cpu_rdata === e, tag, $sformatf("read @%h", a), 32'(cpu_rdata), 32'(e));
    endtask

    task automatic chk_box(input int box, input string tag);
        for (int b = 0; b < 16; b++) chk_rd(8'((box << 4) | b), tag);
    endtask

    task automatic store(input logic [3:0] b, input logic [119:0] f);
        cyc(1'b1, b, f, 1'b0, 8'h00, 8'h00, 1'b0, 4'd0);
    endtask

    task automatic release_box(input logic [3:0] b);
        cyc(1'b0, 4'd0, '0, 1'b0, 8'h00, 8'h00, 1'b1, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL all: watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [119:0] fa, fb, fc, fd, fe;
        int seed_dummy;
        seed_dummy = int'($urandom(32'h5EED1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        #1;
        chk(new_data === '0, "R11", "new_data after reset", 32'(new_data), 32'h0);
        chk(msg_lost === '0, "R11", "msg_lost after reset", 32'(msg_lost), 32'h0);
        chk_box(2, "R11");
        chk_box(15, "R11");

        // R1 byte mapping, R3 store into receive mailbox
        store(4'd2, F_SEQ);
        chk_flags("R3");
        for (int b = 0; b < 15; b++) begin
            cpu_addr = 8'(8'h20 + b);
            #1;
            chk(cpu_rdata === 8'(b), "R1", "byte order", 32'(cpu_rdata), 32'(b));
        end

        // R3 store into transmit mailbox 3 ignored
        store(4'd3, rand_frame());
        chk_flags("R3");
        chk_box(3, "R3");

        // R4 byte write to mailbox 1, ignored write to mailbox 15
        cyc(1'b0, 4'd0, '0, 1'b1, 8'h15, 8'hA5, 1'b0, 4'd0);
        cpu_addr = 8'h15;
        #1;
        chk(cpu_rdata === 8'hA5, "R4", "written byte", 32'(cpu_rdata), 32'hA5);
        cyc(1'b0, 4'd0, '0, 1'b1, 8'hF3, 8'h5A, 1'b0, 4'd0);
        chk_rd(8'hF3, "R4");
        // R4 store and write to same mailbox in one cycle
        fa = rand_frame();
        cyc(1'b1, 4'd4, fa, 1'b1, 8'h40, ~fa[7:0], 1'b0, 4'd0);
        cpu_addr = 8'h40;
        #1;
        chk(cpu_rdata === fa[7:0], "R4", "store beats write", 32'(cpu_rdata), 32'(fa[7:0]));

        // R2 reserved writes ignored, reserved reads zero
        cyc(1'b0, 4'd0, '0, 1'b1, 8'h2F, 8'hFF, 1'b0, 4'd0);
        cyc(1'b0, 4'd0, '0, 1'b1, 8'h05, 8'hFF, 1'b0, 4'd0);
        chk_box(2, "R2");
        chk_rd(8'h05, "R2");
        chk_rd(8'hEF, "R2");

        // R6 overwrite of unread frame, R5 release
        store(4'd2, rand_frame());
        chk_flags("R6");
        chk(msg_lost[1] === 1'b1, "R6", "lost bit", 32'(msg_lost[1]), 32'h1);
        chk_box(2, "R6");
        release_box(4'd2);
        chk_flags("R5");
        chk(new_data[1] === 1'b0, "R5", "new_data clear", 32'(new_data[1]), 32'h0);

        // R7 alternation in mailbox 15
        fa = rand_frame(); fb = rand_frame(); fc = rand_frame();
        fd = rand_frame(); fe = rand_frame();
        store(4'd15, fa);
        chk_box(15, "R7");
        cpu_addr = 8'hF0;
        #1;
        chk(cpu_rdata === fa[7:0], "R7", "first frame in window", 32'(cpu_rdata), 32'(fa[7:0]));
        store(4'd15, fb);
        cpu_addr = 8'hF0;
        #1;
        chk(cpu_rdata === fa[7:0], "R7", "window keeps first", 32'(cpu_rdata), 32'(fa[7:0]));
        chk_flags("R7");
        // R8 third frame overwrites newer buffer
        store(4'd15, fc);
        chk(msg_lost[14] === 1'b1, "R8", "lost bit", 32'(msg_lost[14]), 32'h1);
        chk_box(15, "R8");
        // R9 release switches window to newer frame
        release_box(4'd15);
        cpu_addr = 8'hF0;
        #1;
        chk(cpu_rdata === fc[7:0], "R9", "window switched", 32'(cpu_rdata), 32'(fc[7:0]));
        chk(new_data[14] === 1'b1, "R9", "new_data held", 32'(new_data[14]), 32'h1);
        release_box(4'd15);
        chk(new_data[14] === 1'b0, "R9", "new_data clear", 32'(new_data[14]), 32'h0);
        // R10 store and release on the same buffer
        cyc(1'b1, 4'd15, fd, 1'b0, 8'h00, 8'h00, 1'b1, 4'd15);
        chk(new_data[14] === 1'b1, "R10", "new_data kept", 32'(new_data[14]), 32'h1);
        chk_box(15, "R10");
        // R9 release of window while store goes to the other buffer
        cyc(1'b1, 4'd15, fe, 1'b0, 8'h00, 8'h00, 1'b1, 4'd15);
        cpu_addr = 8'hF0;
        #1;
        chk(cpu_rdata === fe[7:0], "R9", "window follows store", 32'(cpu_rdata), 32'(fe[7:0]));
        chk_flags("R9");

        // random mix, all requirements against the model
        for (int n = 0; n < 3000; n++) begin
            logic sv, w, rl;
            logic [3:0] sb, rb;
            logic [7:0] wa, wd;
            sv = ($urandom_range(0, 99) < 30);
            sb = 4'($urandom_range(1, 15));
            w  = ($urandom_range(0, 99) < 30);
            wa = 8'($urandom_range(0, 255));
            wd = 8'($urandom_range(0, 255));
            rl = ($urandom_range(0, 99) < 25);
            rb = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(1, 15));
            if (n % 500 == 0) tx_mode = 14'($urandom_range(0, 16383));
            cyc(sv, sb, rand_frame(), w, wa, wd, rl, rb);
            chk_flags("R5 R6 R8");
            chk_rd(8'($urandom_range(0, 255)), "R1 R4 R9");
            chk_rd({4'hF, 4'($urandom_range(0, 15))}, "R7 R8");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule